// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals of an incremental encoder into a 32-bit position count. It also keeps a revolution count and raises per-event status flags. Two reference inputs, an index mark and a home switch, can reload the position with a programmed start value on a chosen edge. An optional modulo mode makes the count wrap between the start value and a programmed upper bound.

The host reaches the block through a plain 16-bit register port. Every write and every read takes one cycle, and read data is combinational in the cycle of the read. Wide values are written and read as upper and lower halves. Reading the upper position half captures the lower half at the same moment, so a 32-bit position read over two bus cycles is always coherent.

Status flags are sticky and are cleared by writing ones. One interrupt line combines the flags that are enabled.

Top module: `qdec_top`

Register addresses: 0 control, 1 interrupt enable, 2 status, 3/4 start value upper/lower, 5/6 modulus upper/lower, 7/8 compare upper/lower, 9 position upper, 10 held lower position, 11 revolution count.

Control bits:

| Bit | Function |
|-----|----------|
| 0 | reverse direction |
| 1 | single-phase mode |
| 2 | home enable |
| 3 | home falling edge |
| 4 | index enable |
| 5 | index falling edge |
| 6 | modulo enable |
| 7 | revolution count on wrap |
| 8 | compare-on-read |
| 9 | software load (write-only, reads 0) |

Flag bits, used in the status register, the interrupt-enable register and the `flags` port:

| Bit | Flag |
|-----|------|
| 0 | home |
| 1 | index |
| 2 | compare |
| 3 | simultaneous phase change |
| 4 | roll-over |
| 5 | roll-under |

Status bit 6 is read-only and reports the last count direction (1 = up).

## Requirements
- R1: In quadrature mode, each single-phase change of the sequence {A,B} = 00→10→11→01→00 counts the position up by one, and the opposite order counts down by one. With control bit 0 set, the sense of counting is inverted.
- R2: With control bit 1 set, each rising edge of A counts one step: up when B is 0, down when B is 1. Falling edges of A and all changes of B make no count.
- R3: A rising edge (edge-select bit 0) or a falling edge (edge-select bit 1) of index or home loads the start value into the position when that input's enable bit is set. Writing 1 to control bit 9 also loads the start value, and bit 9 reads back as 0.
- R4: In quadrature mode, a sample in which A and B both change makes no count and sets flag 3.
- R5: In modulo mode, counting up from the modulus loads the start value and sets flag 4, and counting down from the start value loads the modulus and sets flag 5. Outside modulo mode, flags 4 and 5 set on the 32-bit wrap up from all ones and down from zero.
- R6: With control bit 7 clear, the revolution count steps on each selected index edge: up if the last count was up, down otherwise. With bit 7 set, it steps +1 on each modulo roll-over and −1 on each modulo roll-under.
- R7: Reading the upper position half captures the lower half at that cycle. The held register returns the captured value even when the count changes before it is read. It resets to 0.
- R8: The compare output is high while the position equals the compare value, which resets to all ones. With control bit 8 set, the output instead pulses for one cycle after any read of addresses 9 or 10. Flag 2 sets one cycle after the compare output is high.
- R9: Flags are sticky. Writing 1 to a status bit clears that flag, writing 0 leaves it unchanged, and status bit 6 shows the last count direction.
- R10: `irq` is high exactly when some flag is set and its enable bit is set.
- R11: After reset, the position, flags, held lower half and interrupt line are 0, and the compare value is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| phaseA | input | 1 | Encoder phase A (asynchronous) |
| phaseB | input | 1 | Encoder phase B (asynchronous) |
| indexIn | input | 1 | Index mark (asynchronous) |
| homeIn | input | 1 | Home switch (asynchronous) |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, valid in the read cycle |
| flags | output | 6 | Sticky status flags |
| irq | output | 1 | OR of enabled, set flags |
| cmpOut | output | 1 | Compare match output |

## Verification
A change on any encoder or reference input passes through two synchroniser flops and one previous-value flop. The position, revolution count and held half therefore settle on the third clock edge after the input is applied. The bench applies each input change and waits four cycles before reading or checking any port.

Register writes take effect at the next edge. The flag for an event appears one edge after the event. In compare-on-read mode the compare pulse occupies the cycle right after the read, and the flag follows one cycle later. The scoreboard samples each of these in its exact cycle, a quarter period before the rising edge.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned FLAG_N = 6;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN      = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT     = 4'd2;
  localparam logic [ADDR_W-1:0] A_INIT_HI  = 4'd3;
  localparam logic [ADDR_W-1:0] A_INIT_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MOD_HI   = 4'd5;
  localparam logic [ADDR_W-1:0] A_MOD_LO   = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMP_HI   = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMP_LO   = 4'd8;
  localparam logic [ADDR_W-1:0] A_POS_HI   = 4'd9;
  localparam logic [ADDR_W-1:0] A_POS_HOLD = 4'd10;
  localparam logic [ADDR_W-1:0] A_REV      = 4'd11;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic countUp;
    logic countDn;
    logic loadInit;
    logic idxEvt;
    logic dirUp;   // last counted direction, used by the revolution count
  } qdStrobe_t;
endpackage

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
#(
  parameter int unsigned POS_W       = 32,
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseA,
  input  logic              phaseB,
  input  logic              indexIn,
  input  logic              homeIn,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  logic [POS_W-1:0]  posVal,
  input  logic [BUS_W-1:0]  holdLo,
  input  logic [BUS_W-1:0]  revVal,
  input  logic              cmpOut,
  input  logic              rollOver,
  input  logic              rollUnder,
  output qdStrobe_t         strobe,
  output logic [POS_W-1:0]  initVal,
  output logic [POS_W-1:0]  modVal,
  output logic [POS_W-1:0]  cmpVal,
  output logic              modEn,
  output logic              revOnWrap,
  output logic              cmpOnRead,
  output logic              rdPosHi,
  output logic              rdPosAny,
  output logic [FLAG_N-1:0] flags,
  output logic              irq
);
  localparam int unsigned HALF   = BUS_W;
  localparam int unsigned CTRL_W = 9;

  logic [CTRL_W-1:0] ctrlReg;
  logic [FLAG_N-1:0] irqEn, flagReg, flagSet, flagClr;
  logic              lastUp;

  // two-flop synchronisers on all four asynchronous inputs
  logic [3:0] rawIn, syncd, prevS;
  assign rawIn = {homeIn, indexIn, phaseB, phaseA};

  for (genvar g = 0; g < 4; g++) begin : gSync
    logic [SYNC_STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sh <= '0;
      else       sh <= {sh[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncd[g] = sh[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevS <= '0;
    else       prevS <= syncd;
  end

  // step decode
  logic aChg, bChg, singlePh, illegal, stepEn, rawUp, dirUp;
  logic idxEdge, homeEdge, swLoad, wrHit;
  assign singlePh = ctrlReg[1];
  assign aChg     = syncd[0] ^ prevS[0];
  assign bChg     = syncd[1] ^ prevS[1];
  assign illegal  = !singlePh && aChg && bChg;
  assign stepEn   = singlePh ? (syncd[0] && !prevS[0]) : (aChg ^ bChg);
  assign rawUp    = singlePh ? !syncd[1] : (syncd[0] ^ prevS[1]);
  assign dirUp    = rawUp ^ ctrlReg[0];
  assign idxEdge  = ctrlReg[5] ? (prevS[2] && !syncd[2]) : (!prevS[2] && syncd[2]);
  assign homeEdge = ctrlReg[3] ? (prevS[3] && !syncd[3]) : (!prevS[3] && syncd[3]);
  assign wrHit    = regWr && (regAddr == A_CTRL);
  assign swLoad   = wrHit && regWdata[9];

  always_comb begin
    strobe.countUp  = stepEn && dirUp;
    strobe.countDn  = stepEn && !dirUp;
    strobe.loadInit = swLoad || (ctrlReg[4] && idxEdge) || (ctrlReg[2] && homeEdge);
    strobe.idxEvt   = idxEdge;
    strobe.dirUp    = lastUp;
  end

  assign modEn     = ctrlReg[6];
  assign revOnWrap = ctrlReg[7];
  assign cmpOnRead = ctrlReg[8];
  assign rdPosHi   = regRd && (regAddr == A_POS_HI);
  assign rdPosAny  = rdPosHi || (regRd && (regAddr == A_POS_HOLD));

  // flag bit order: home, index, compare, simultaneous, roll-over, roll-under
  assign flagSet = {rollUnder, rollOver, illegal, cmpOut, idxEdge, homeEdge};
  assign flagClr = (regWr && regAddr == A_STAT) ? regWdata[FLAG_N-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      irqEn   <= '0;
      flagReg <= '0;
      lastUp  <= 1'b0;
      initVal <= '0;
      modVal  <= '0;
      cmpVal  <= '1;
    end else begin
      flagReg <= (flagReg & ~flagClr) | flagSet;
      if (stepEn) lastUp <= dirUp;
      if (regWr) begin
        unique case (regAddr)
          A_CTRL:    ctrlReg <= regWdata[CTRL_W-1:0];
          A_IEN:     irqEn   <= regWdata[FLAG_N-1:0];
          A_INIT_HI: initVal[POS_W-1 -: HALF] <= regWdata;
          A_INIT_LO: initVal[HALF-1:0]        <= regWdata;
          A_MOD_HI:  modVal[POS_W-1 -: HALF]  <= regWdata;
          A_MOD_LO:  modVal[HALF-1:0]         <= regWdata;
          A_CMP_HI:  cmpVal[POS_W-1 -: HALF]  <= regWdata;
          A_CMP_LO:  cmpVal[HALF-1:0]         <= regWdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      A_CTRL:     regRdata = BUS_W'(ctrlReg);
      A_IEN:      regRdata = BUS_W'(irqEn);
      A_STAT:     regRdata = BUS_W'({lastUp, flagReg});
      A_INIT_HI:  regRdata = initVal[POS_W-1 -: HALF];
      A_INIT_LO:  regRdata = initVal[HALF-1:0];
      A_MOD_HI:   regRdata = modVal[POS_W-1 -: HALF];
      A_MOD_LO:   regRdata = modVal[HALF-1:0];
      A_CMP_HI:   regRdata = cmpVal[POS_W-1 -: HALF];
      A_CMP_LO:   regRdata = cmpVal[HALF-1:0];
      A_POS_HI:   regRdata = posVal[POS_W-1 -: HALF];
      A_POS_HOLD: regRdata = holdLo;
      A_REV:      regRdata = revVal;
      default:    regRdata = '0;
    endcase
  end

  assign flags = flagReg;
  assign irq   = |(flagReg & irqEn);

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> flagReg[3]); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == A_STAT) |=> ((flagReg & $past(flagReg)) == $past(flagReg))); // R9
endmodule

// File: rtl/qdec_dp.sv
module qdec_dp
  import qdec_pkg::*;
#(
  parameter int unsigned POS_W = 32,
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qdStrobe_t        strobe,
  input  logic             modEn,
  input  logic             revOnWrap,
  input  logic             cmpOnRead,
  input  logic [POS_W-1:0] initVal,
  input  logic [POS_W-1:0] modVal,
  input  logic [POS_W-1:0] cmpVal,
  input  logic             rdPosHi,
  input  logic             rdPosAny,
  output logic [POS_W-1:0] posVal,
  output logic [BUS_W-1:0] holdLo,
  output logic [BUS_W-1:0] revVal,
  output logic             cmpOut,
  output logic             rollOver,
  output logic             rollUnder
);
  localparam int unsigned HALF  = BUS_W;
  localparam int unsigned REV_W = BUS_W;

  logic [POS_W-1:0] posNext;
  logic [REV_W-1:0] revNext;
  logic             readPulse;

  always_comb begin
    posNext   = posVal;
    rollOver  = 1'b0;
    rollUnder = 1'b0;
    if (strobe.loadInit) begin
      posNext = initVal;
    end else if (strobe.countUp) begin
      if (modEn && posVal == modVal) begin
        posNext  = initVal;
        rollOver = 1'b1;
      end else begin
        posNext  = posVal + 1'b1;
        rollOver = !modEn && (&posVal);
      end
    end else if (strobe.countDn) begin
      if (modEn && posVal == initVal) begin
        posNext   = modVal;
        rollUnder = 1'b1;
      end else begin
        posNext   = posVal - 1'b1;
        rollUnder = !modEn && (posVal == '0);
      end
    end
  end

  always_comb begin
    revNext = revVal;
    if (revOnWrap) begin
      if (rollOver && modEn)       revNext = revVal + 1'b1;
      else if (rollUnder && modEn) revNext = revVal - 1'b1;
    end else if (strobe.idxEvt) begin
      revNext = strobe.dirUp ? revVal + 1'b1 : revVal - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posVal    <= '0;
      revVal    <= '0;
      holdLo    <= '0;
      readPulse <= 1'b0;
    end else begin
      posVal    <= posNext;
      revVal    <= revNext;
      readPulse <= rdPosAny;
      if (rdPosHi) holdLo <= posVal[HALF-1:0];
    end
  end

  assign cmpOut = cmpOnRead ? readPulse : (posVal == cmpVal);

  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadInit |=> posVal == $past(initVal)); // R3
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countUp && !strobe.loadInit && modEn && posVal == modVal) |=> posVal == $past(initVal)); // R5
  AST_WRAP_DN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countDn && !strobe.loadInit && modEn && posVal == initVal) |=> posVal == $past(modVal)); // R5
  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rstN)
    rdPosHi |=> holdLo == $past(posVal[HALF-1:0])); // R7
  AST_REV_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (revOnWrap && modEn && rollOver) |=> revVal == REV_W'($past(revVal) + 1'b1)); // R6
endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int unsigned POS_W       = 32,
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        phaseA,
  input  logic        phaseB,
  input  logic        indexIn,
  input  logic        homeIn,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [3:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  output logic [5:0]  flags,
  output logic        irq,
  output logic        cmpOut
);
  qdStrobe_t        strobe;
  logic [POS_W-1:0] posVal, initVal, modVal, cmpVal;
  logic [BUS_W-1:0] holdLo, revVal;
  logic             modEn, revOnWrap, cmpOnRead, rdPosHi, rdPosAny;
  logic             rollOver, rollUnder;

  qdec_ctrl #(.POS_W(POS_W), .BUS_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .indexIn(indexIn), .homeIn(homeIn), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .posVal(posVal), .holdLo(holdLo), .revVal(revVal), .cmpOut(cmpOut),
    .rollOver(rollOver), .rollUnder(rollUnder), .strobe(strobe),
    .initVal(initVal), .modVal(modVal), .cmpVal(cmpVal), .modEn(modEn),
    .revOnWrap(revOnWrap), .cmpOnRead(cmpOnRead), .rdPosHi(rdPosHi),
    .rdPosAny(rdPosAny), .flags(flags), .irq(irq)
  );

  qdec_dp #(.POS_W(POS_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modEn(modEn),
    .revOnWrap(revOnWrap), .cmpOnRead(cmpOnRead), .initVal(initVal),
    .modVal(modVal), .cmpVal(cmpVal), .rdPosHi(rdPosHi), .rdPosAny(rdPosAny),
    .posVal(posVal), .holdLo(holdLo), .revVal(revVal), .cmpOut(cmpOut),
    .rollOver(rollOver), .rollUnder(rollUnder)
  );
endmodule

// File: tb/sim_qdec_top.sv
`timescale 1ns/1ps
module sim_qdec_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseA = 1'b0, phaseB = 1'b0, indexIn = 1'b0, homeIn = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0, portChk = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [5:0]  flags;
  logic        irq, cmpOut;

  int vecs = 0;
  int errs = 0;
  int qState = 0;
  bit done = 0;

  typedef struct {
    bit          isPort;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;   // 50 MHz

  qdec_top u0 (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .indexIn(indexIn), .homeIn(homeIn), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .flags(flags), .irq(irq), .cmpOut(cmpOut)
  );

  // monitor: samples 5 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (regRd || portChk) begin
        item_t it;
        logic [15:0] act;
        if (sb.size() == 0) begin
          errs++;
          $display("FAIL scoreboard empty: act=%h exp=none", regRdata);
        end else begin
          it  = sb.pop_front();
          act = it.isPort ? {8'h00, cmpOut, irq, flags} : regRdata;
          vecs++;
          if (act !== it.exp) begin
            errs++;
            $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.isPort = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  // expected port word: bit7 cmpOut, bit6 irq, bits5:0 flags
  task automatic chk(input logic [15:0] e, input string tag);
    item_t it;
    it.isPort = 1'b1; it.exp = e; it.tag = tag;
    sb.push_back(it);
    portChk = 1'b1;
    @(negedge clk);
    portChk = 1'b0;
  endtask

  task automatic rdPos(input logic [31:0] e, input string tag);
    rd(4'd9, e[31:16], tag);
    rd(4'd10, e[15:0], tag);
  endtask

  task automatic driveQ();
    case (qState)
      0: {phaseA, phaseB} = 2'b00;
      1: {phaseA, phaseB} = 2'b10;
      2: {phaseA, phaseB} = 2'b11;
      default: {phaseA, phaseB} = 2'b01;
    endcase
    tick(4);
  endtask

  task automatic stepUp(input int n);
    for (int i = 0; i < n; i++) begin
      qState = (qState + 1) % 4;
      driveQ();
    end
  endtask

  task automatic stepDn(input int n);
    for (int i = 0; i < n; i++) begin
      qState = (qState + 3) % 4;
      driveQ();
    end
  endtask

  task automatic setAB(input logic a, input logic b);
    phaseA = a; phaseB = b;
    tick(4);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: act=timeout exp=finish");
      summary();
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R11 reset state
    rdPos(32'h0, "R11 position");
    rd(4'd7, 16'hFFFF, "R11 compare reset");
    chk(16'h0000, "R11 ports");
    wr(4'd1, 16'h003F);

    // R1 up count
    stepUp(5);
    rdPos(32'd5, "R1 up count");
    rd(4'd2, 16'h0040, "R9 dir up");
    // R1 down through zero, R5 roll-under, R8 passes all-ones compare
    stepDn(7);
    rdPos(32'hFFFF_FFFE, "R1 down count");
    chk(16'h0064, "R5/R8/R10 flags after roll-under");
    rd(4'd2, 16'h0024, "R9 dir down");
    wr(4'd2, 16'h0000);
    chk(16'h0064, "R9 write zero keeps flags");
    wr(4'd2, 16'h0024);
    chk(16'h0000, "R9 write one clears");

    // R1 reverse
    wr(4'd0, 16'h0001);
    stepUp(3);
    rdPos(32'hFFFF_FFFB, "R1 reverse");
    wr(4'd0, 16'h0000);

    // R4 illegal
    qState = (qState + 2) % 4;
    driveQ();
    rdPos(32'hFFFF_FFFB, "R4 no count");
    chk(16'h0048, "R4 simultaneous flag");
    wr(4'd1, 16'h0000);
    chk(16'h0008, "R10 irq masked");
    wr(4'd1, 16'h003F);
    wr(4'd2, 16'h003F);

    // R3 software load
    wr(4'd3, 16'h0000);
    wr(4'd4, 16'd10);
    wr(4'd0, 16'h0200);
    tick(1);
    rdPos(32'd10, "R3 software load");
    rd(4'd0, 16'h0000, "R3 load bit self-clears");

    // R5 modulo wrap up
    wr(4'd5, 16'h0000);
    wr(4'd6, 16'd13);
    wr(4'd0, 16'h0040);
    stepUp(3);
    rdPos(32'd13, "R5 reach modulus");
    stepUp(1);
    rdPos(32'd10, "R5 wrap to start");
    chk(16'h0050, "R5 roll-over flag");
    rd(4'd11, 16'h0000, "R6 no index no rev");
    wr(4'd2, 16'h003F);
    // R6 revolution on wrap
    wr(4'd0, 16'h00C0);
    stepDn(1);
    rdPos(32'd13, "R5 wrap down to modulus");
    rd(4'd11, 16'hFFFF, "R6 rev down on roll-under");
    chk(16'h0060, "R5 roll-under flag");
    stepUp(1);
    rd(4'd11, 16'h0000, "R6 rev up on roll-over");
    wr(4'd2, 16'h003F);

    // R3 index rising
    wr(4'd4, 16'd100);
    wr(4'd0, 16'h0010);
    indexIn = 1'b1; tick(4);
    rdPos(32'd100, "R3 index rising load");
    rd(4'd11, 16'h0001, "R6 rev on index");
    stepUp(1);
    indexIn = 1'b0; tick(4);
    rdPos(32'd101, "R3 falling ignored in rising mode");
    // R3 index falling
    wr(4'd0, 16'h0030);
    indexIn = 1'b1; tick(4);
    rdPos(32'd101, "R3 rising ignored in falling mode");
    indexIn = 1'b0; tick(4);
    rdPos(32'd100, "R3 index falling load");
    rd(4'd11, 16'h0002, "R6 rev second index");
    wr(4'd2, 16'h003F);
    // R3 home rising
    wr(4'd0, 16'h0004);
    stepUp(1);
    homeIn = 1'b1; tick(4);
    rdPos(32'd100, "R3 home load");
    chk(16'h0041, "R3 home flag");
    homeIn = 1'b0; tick(4);
    wr(4'd2, 16'h003F);

    // R2 single-phase
    wr(4'd0, 16'h0002);
    setAB(1'b0, 1'b0);
    setAB(1'b1, 1'b0);
    setAB(1'b0, 1'b0);
    setAB(1'b1, 1'b0);
    setAB(1'b1, 1'b1);
    setAB(1'b0, 1'b1);
    setAB(1'b1, 1'b1);
    rdPos(32'd101, "R2 single-phase");
    rd(4'd2, 16'h0000, "R9 dir after single-phase down");
    wr(4'd0, 16'h0000);
    qState = 2;

    // R8 compare equal
    wr(4'd7, 16'h0000);
    wr(4'd8, 16'd103);
    stepUp(2);
    chk(16'h00C4, "R8 compare match");
    stepUp(1);
    chk(16'h0044, "R8 flag sticky after match");
    wr(4'd2, 16'h003F);
    // R8 compare on read
    wr(4'd0, 16'h0100);
    chk(16'h0000, "R8 read mode idle");
    rd(4'd9, 16'h0000, "R8 read upper");
    chk(16'h0080, "R8 read pulse");
    chk(16'h0044, "R8 read pulse flag");
    wr(4'd2, 16'h003F);

    // R7 snapshot coherence
    wr(4'd0, 16'h0000);
    rd(4'd9, 16'h0000, "R7 upper");
    stepUp(1);
    rd(4'd10, 16'd104, "R7 held lower ignores later count");
    wr(4'd4, 16'hFFFF);
    wr(4'd0, 16'h0200);
    tick(1);
    rd(4'd9, 16'h0000, "R7 upper before carry");
    stepUp(1);
    rd(4'd10, 16'hFFFF, "R7 held lower across carry");
    rdPos(32'h0001_0000, "R7 after carry");

    tick(2);
    done = 1;
    summary();
  end
endmodule